// File: doc/BRIEF.md
# Streaming CRC Checker and Stripper

This block sits on the receive side of a framed byte stream whose handshake signals are all active low. Every frame arrives with four check bytes appended after its payload. The block works out a CRC-32 over the payload bytes as they pass. It compares the result with the four trailing bytes. It then forwards the payload with those bytes removed. Because the check bytes can fill the final input beat or spill across the last two beats, the block keeps one beat back. This lets it move end-of-frame onto the true last payload byte and rewrite the remainder, and it drops the final input beat when that beat holds nothing but check bytes.

The outcome of the comparison is reported with a one-cycle strobe and an active-low failure flag, both aligned with the outgoing end-of-frame beat. The bus width is 32 or 64 bits. The start value and four optional transforms are parameters: complement of input bytes, bit reversal of input bytes, bit reversal of each result byte, and complement of the result. A transmit-side inserter built with the same settings produces streams that this block accepts.

Top module: `crcs_strip_check`

## Requirements
- R1: An upstream beat is taken only on a rising clock edge where both in_src_rdy_n and in_dst_rdy_n are low; beats offered with in_src_rdy_n high, including idle gaps inside a frame, leave no trace on the output stream.
- R2: in_dst_rdy_n carries the value of out_dst_rdy_n in the same cycle, with no register between them.
- R3: The payload bytes reach the output in their original order and unchanged, with the four check bytes removed; byte 0 of a beat sits in the most significant byte lane (bits DATA_W-1 down to DATA_W-8).
- R4: The output end-of-frame beat is the beat holding the last payload byte, and out_rem gives that byte's lane index in binary, 0 meaning only the most significant lane is valid. This holds whether the check bytes share the last beat with payload, fill it exactly, or spill over from the previous beat.
- R5: Within every valid output beat, lanes after out_rem are driven to zero.
- R6: chk_strobe is high for exactly one cycle per frame, in the first cycle in which the frame's end-of-frame beat is presented, and low at all other times.
- R7: When chk_strobe is high, chk_fail_n is 1 if the received check bytes equal the computed value and 0 otherwise, so any single flipped bit in the payload or in the check bytes yields 0.
- R8: The computed value is CRC-32 with generator 0x04C11DB7, shifted most significant bit first from CRC_INIT. Each payload byte is first complemented when COMP_DATA is set, then bit reversed when REV_DATA is set. The final register is bit reversed within each byte when REV_CRC is set, then complemented when COMP_CRC is set. Its bits 31:24 are the first check byte on the wire.
- R9: Each start-of-frame restarts the calculation from CRC_INIT, so frames sent back to back with no idle cycle are each judged on their own.
- R10: While rst_n is low at a clock edge, the next cycle shows out_src_rdy_n high, chk_strobe low and chk_fail_n high.
- R11: While a valid output beat is refused (out_dst_rdy_n high), it stays presented with data, remainder and end-of-frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | DATA_W | Upstream beat data, byte 0 in the top lane |
| in_rem | input | log2(DATA_W/8) | Upstream index of the last valid lane, meaningful on end-of-frame |
| in_sof_n | input | 1 | Upstream start-of-frame, active low |
| in_eof_n | input | 1 | Upstream end-of-frame, active low |
| in_src_rdy_n | input | 1 | Upstream beat offered, active low |
| in_dst_rdy_n | output | 1 | Block can take an upstream beat, active low |
| out_data | output | DATA_W | Downstream payload data |
| out_rem | output | log2(DATA_W/8) | Downstream index of the last payload lane |
| out_sof_n | output | 1 | Downstream start-of-frame, active low |
| out_eof_n | output | 1 | Downstream end-of-frame, active low |
| out_src_rdy_n | output | 1 | Downstream beat offered, active low |
| out_dst_rdy_n | input | 1 | Downstream sink ready, active low |
| chk_strobe | output | 1 | One-cycle pulse qualifying chk_fail_n |
| chk_fail_n | output | 1 | 1 on a matching check, 0 on a mismatch |

## Verification
Frames of payload lengths from one to twenty bytes are pushed through a 64-bit instance, so the final beat carries more than four bytes, exactly four, or fewer than four. These three cases exercise the same-beat end, the dropped-beat end and the spill-over end of the realignment. The same table is first streamed back to back, which separates a correct restart at start-of-frame from a carried-over value. It is then streamed again with idle gaps inside frames and periodic downstream stalls, which separates a correct handshake from one that duplicates or loses beats and strobes. Some frames carry a single flipped bit, placed in the payload, in the first check byte or in the last check byte. A clean frame that reports pass tells a correct comparison apart from one that never fails, and each corrupted frame tells it apart from one that never passes or looks at the wrong lanes.

// File: rtl/crcs_pkg.sv
// Package: CRC-32 helpers shared by the checker datapath.
// Assumes generator 0x04C11DB7, shifted most significant bit first.
package crcs_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    // Mirror the bit order of one byte.
    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // Advance the CRC register by one byte, MSB first.
    function automatic logic [31:0] step8(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

    // Apply the optional result transforms: per-byte mirror, then inversion.
    function automatic logic [31:0] crc_finish(input logic [31:0] c, input bit rev, input bit comp);
        logic [31:0] r;
        r = c;
        if (rev) for (int j = 0; j < 4; j++) r[8*j +: 8] = rev8(c[8*j +: 8]);
        if (comp) r = ~r;
        return r;
    endfunction

endpackage

// File: rtl/crcs_lane_calc.sv
// Folds lanes 0..last_idx of one beat into a CRC seed, lane 0 first.
// Assumes lane 0 is the most significant byte of data.
module crcs_lane_calc #(
    parameter int unsigned NB        = 4,
    parameter int unsigned RW        = 2,
    parameter bit          REV_DATA  = 1'b0,
    parameter bit          COMP_DATA = 1'b0
) (
    input  logic [31:0]     seed,
    input  logic [8*NB-1:0] data,
    input  logic [RW-1:0]   last_idx,
    output logic [31:0]     crc_out
);
    import crcs_pkg::*;

    // Serial byte fold, unrolled across the lanes of the beat.
    always_comb begin
        logic [31:0] c;
        logic [7:0]  b;
        c = seed;
        for (int j = 0; j < int'(NB); j++) begin
            b = data[8*NB-1-8*j -: 8];
            if (COMP_DATA) b = ~b;
            if (REV_DATA)  b = rev8(b);
            if (j <= int'(last_idx)) c = step8(c, b);
        end
        crc_out = c;
    end
endmodule

// File: rtl/crcs_tail_pick.sv
// Extracts four consecutive bytes from a two-beat window starting at byte 'first'.
// Assumes first + 3 stays inside the window; byte 0 is the top of the window.
module crcs_tail_pick #(
    parameter int unsigned NB = 4,
    parameter int unsigned RW = 2
) (
    input  logic [16*NB-1:0] window,
    input  logic [RW:0]      first,
    output logic [31:0]      tail
);
    logic [16*NB-1:0] shifted;

    // Left-align the chosen byte, then take the top four bytes.
    always_comb begin
        shifted = window << {first, 3'b000};
        tail    = shifted[16*NB-1 -: 32];
    end
endmodule

// File: rtl/crcs_strip_check.sv
// Receive-side CRC checker that strips the four trailing check bytes.
// One upstream beat is held back so end-of-frame can be moved onto the
// last payload byte; the CRC is folded in as beats leave the hold stage.
// Assumes every frame has at least one payload byte.
module crcs_strip_check #(
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] CRC_INIT  = 32'hFFFF_FFFF,
    parameter bit          REV_DATA  = 1'b0,
    parameter bit          COMP_DATA = 1'b0,
    parameter bit          REV_CRC   = 1'b0,
    parameter bit          COMP_CRC  = 1'b0,
    localparam int unsigned NB       = DATA_W / 8,
    localparam int unsigned RW       = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic [RW-1:0]     in_rem,
    input  logic              in_sof_n,
    input  logic              in_eof_n,
    input  logic              in_src_rdy_n,
    output logic              in_dst_rdy_n,
    output logic [DATA_W-1:0] out_data,
    output logic [RW-1:0]     out_rem,
    output logic              out_sof_n,
    output logic              out_eof_n,
    output logic              out_src_rdy_n,
    input  logic              out_dst_rdy_n,
    output logic              chk_strobe,
    output logic              chk_fail_n
);
    import crcs_pkg::*;

    localparam logic [RW-1:0] LAST_LANE = RW'(NB - 1);
    localparam logic [RW-1:0] SPILL_OFS = RW'(NB - 4);
    localparam logic [RW-1:0] FOUR      = RW'(4);

    logic              adv, take, x_eof, x_small, strip, move_h, move_eof;
    logic [RW:0]       x_nb, tail_at;
    logic [RW-1:0]     pay_last;
    logic              h_vld, h_fin, h_sof;
    logic [DATA_W-1:0] h_data, h_masked;
    logic [RW-1:0]     h_rem;
    logic              o_vld;
    logic [31:0]       run_crc, base_crc, new_crc, rx_tail, want;

    assign in_dst_rdy_n  = out_dst_rdy_n;
    assign out_src_rdy_n = ~o_vld;

    // Decide what moves this cycle and where the payload of the held beat ends.
    always_comb begin
        adv      = ~out_dst_rdy_n;
        take     = adv & ~in_src_rdy_n;
        x_eof    = ~in_eof_n;
        x_nb     = {1'b0, in_rem} + (RW+1)'(1);
        x_small  = x_nb <= (RW+1)'(4);
        strip    = take & x_eof & x_small & h_vld & ~h_fin;
        move_h   = adv & h_vld & (h_fin | take);
        move_eof = move_h & (h_fin | strip);
        if (h_fin)      pay_last = h_rem;
        else if (strip) pay_last = in_rem + SPILL_OFS;
        else            pay_last = LAST_LANE;
        base_crc = h_sof ? CRC_INIT : run_crc;
        tail_at  = {1'b0, pay_last} + (RW+1)'(1);
        want     = crc_finish(new_crc, REV_CRC, COMP_CRC);
    end

    // Clear the lanes after the last payload byte of the held beat.
    always_comb begin
        h_masked = h_data;
        for (int j = 0; j < int'(NB); j++)
            if (j > int'(pay_last)) h_masked[DATA_W-1-8*j -: 8] = 8'h00;
    end

    crcs_lane_calc #(
        .NB(NB), .RW(RW), .REV_DATA(REV_DATA), .COMP_DATA(COMP_DATA)
    ) u_calc (
        .seed(base_crc), .data(h_data), .last_idx(pay_last), .crc_out(new_crc)
    );

    crcs_tail_pick #(.NB(NB), .RW(RW)) u_tail (
        .window({h_data, in_data}), .first(tail_at), .tail(rx_tail)
    );

    // Hold stage: keeps one beat back until its role in the frame is known.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vld  <= 1'b0;
            h_fin  <= 1'b0;
            h_sof  <= 1'b0;
            h_rem  <= '0;
            h_data <= '0;
        end else if (take && !strip) begin
            h_vld  <= 1'b1;
            h_data <= in_data;
            h_sof  <= ~in_sof_n;
            h_fin  <= x_eof;
            h_rem  <= x_eof ? in_rem - FOUR : in_rem;
        end else if (move_h) begin
            h_vld  <= 1'b0;
        end
    end

    // Running CRC over payload that has already left the hold stage.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_crc <= CRC_INIT;
        else if (move_h) run_crc <= new_crc;
    end

    // Output stage and check report, advanced only when downstream accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld      <= 1'b0;
            out_data   <= '0;
            out_rem    <= '0;
            out_sof_n  <= 1'b1;
            out_eof_n  <= 1'b1;
            chk_strobe <= 1'b0;
            chk_fail_n <= 1'b1;
        end else if (adv) begin
            o_vld      <= move_h;
            chk_strobe <= move_eof;
            if (move_h) begin
                out_data  <= h_masked;
                out_rem   <= pay_last;
                out_sof_n <= ~h_sof;
                out_eof_n <= ~move_eof;
            end
            if (move_eof) chk_fail_n <= (want == rx_tail);
        end else begin
            chk_strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/crcs_strip_check_sva.sv
// Property checker for crcs_strip_check, attached through bind below.
// Assumes the same DATA_W as the instance it watches.
module crcs_strip_check_sva #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NB    = DATA_W / 8,
    localparam int unsigned RW    = $clog2(NB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] out_data,
    input logic [RW-1:0]     out_rem,
    input logic              out_eof_n,
    input logic              out_src_rdy_n,
    input logic              out_dst_rdy_n,
    input logic              chk_strobe,
    input logic              chk_fail_n
);
    logic pad_bad;

    // Flag any nonzero lane after the remainder of the presented beat.
    always_comb begin
        pad_bad = 1'b0;
        for (int j = 0; j < int'(NB); j++)
            if (j > int'(out_rem) && out_data[DATA_W-1-8*j -: 8] != 8'h00) pad_bad = 1'b1;
    end

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (out_src_rdy_n && !chk_strobe && chk_fail_n));

    p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_src_rdy_n && out_dst_rdy_n) |=>
        (!out_src_rdy_n && $stable(out_data) && $stable(out_rem) && $stable(out_eof_n)));

    p_strobe_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_src_rdy_n && out_dst_rdy_n) |=> !chk_strobe);

    p_strobe_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_strobe |-> (!out_src_rdy_n && !out_eof_n));

    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_src_rdy_n |-> !pad_bad);
endmodule

bind crcs_strip_check crcs_strip_check_sva #(.DATA_W(DATA_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_rem(out_rem),
    .out_eof_n(out_eof_n), .out_src_rdy_n(out_src_rdy_n),
    .out_dst_rdy_n(out_dst_rdy_n), .chk_strobe(chk_strobe), .chk_fail_n(chk_fail_n)
);

// File: tb/crcs_strip_check_test.sv
// Bench: frames with reference check bytes are streamed in, payload and report checked.
module crcs_strip_check_test;
    localparam int DW = 64;
    localparam int NB = DW / 8;
    localparam int RW = $clog2(NB);
    localparam logic [31:0] INIT = 32'hFFFF_FFFF;
    localparam bit RD = 1'b1, CD = 1'b0, RC = 1'b1, CC = 1'b1;
    localparam int MAXF = 32, MAXB = 40;

    // Vector table: payload length and flipped bit (-1 for a clean frame).
    localparam int NV = 12;
    localparam int VLEN  [NV] = '{1, 2, 3, 4, 5, 7, 8, 10, 12, 13, 20, 6};
    localparam int VFLIP [NV] = '{-1, 9, -1, -1, 3, -1, 66, -1, -1, 135, -1, -1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] in_data = '0, out_data;
    logic [RW-1:0] in_rem = '0, out_rem;
    logic in_sof_n = 1'b1, in_eof_n = 1'b1, in_src_rdy_n = 1'b1, in_dst_rdy_n;
    logic out_sof_n, out_eof_n, out_src_rdy_n, out_dst_rdy_n = 1'b0;
    logic chk_strobe, chk_fail_n;

    int checks = 0, errors = 0;
    int nsent = 0, nrecv = 0, rx_n = 0, strobes = 0, cyc = 0;
    bit stall_on = 1'b0, hold_val = 1'b0, done = 1'b0;
    logic [7:0] fb [0:MAXB-1];
    logic [7:0] sent_b [0:MAXF-1][0:MAXB-1];
    logic [7:0] rx_b [0:MAXB-1];
    int  sent_len [0:MAXF-1];
    bit  sent_ok  [0:MAXF-1];

    always #10 clk = ~clk;

    crcs_strip_check #(
        .DATA_W(DW), .CRC_INIT(INIT), .REV_DATA(RD), .COMP_DATA(CD),
        .REV_CRC(RC), .COMP_CRC(CC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_rem(in_rem),
        .in_sof_n(in_sof_n), .in_eof_n(in_eof_n), .in_src_rdy_n(in_src_rdy_n),
        .in_dst_rdy_n(in_dst_rdy_n), .out_data(out_data), .out_rem(out_rem),
        .out_sof_n(out_sof_n), .out_eof_n(out_eof_n), .out_src_rdy_n(out_src_rdy_n),
        .out_dst_rdy_n(out_dst_rdy_n), .chk_strobe(chk_strobe), .chk_fail_n(chk_fail_n)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference CRC over fb[0..n-1] as stated in R8.
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c;
        logic [7:0]  v;
        logic        top;
        c = INIT;
        for (int i = 0; i < n; i++) begin
            v = fb[i];
            if (CD) v = ~v;
            if (RD) v = {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
            for (int k = 7; k >= 0; k--) begin
                top = c[31];
                c = c << 1;
                if (top ^ v[k]) c = c ^ 32'h04C1_1DB7;
            end
        end
        if (RC) for (int j = 0; j < 4; j++)
            c[8*j +: 8] = {c[8*j], c[8*j+1], c[8*j+2], c[8*j+3],
                           c[8*j+4], c[8*j+5], c[8*j+6], c[8*j+7]};
        if (CC) c = ~c;
        return c;
    endfunction

    // Downstream ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        out_dst_rdy_n = stall_on ? (cyc % 4 == 2) : hold_val;
    end

    // Offer one beat and wait until it is taken (called just after an edge).
    task automatic put_beat(input logic [DW-1:0] d, input int rem, input bit sof, input bit eof);
        bit acc;
        in_data = d; in_rem = RW'(rem); in_sof_n = ~sof; in_eof_n = ~eof; in_src_rdy_n = 1'b0;
        do begin
            @(negedge clk); acc = !in_dst_rdy_n;
            @(posedge clk); #1;
        end while (!acc);
        in_src_rdy_n = 1'b1;
    endtask

    task automatic send_frame(input int len, input int flip, input bit gaps);
        logic [31:0] c;
        logic [DW-1:0] w;
        int total, beats;
        for (int i = 0; i < len; i++) fb[i] = 8'(i * 37 + nsent * 11 + 5);
        c = ref_crc(len);
        fb[len] = c[31:24]; fb[len+1] = c[23:16]; fb[len+2] = c[15:8]; fb[len+3] = c[7:0];
        if (flip >= 0) fb[flip / 8][flip % 8] = ~fb[flip / 8][flip % 8];
        for (int i = 0; i < len; i++) sent_b[nsent][i] = fb[i];
        sent_len[nsent] = len;
        sent_ok[nsent]  = (flip < 0);
        nsent++;
        total = len + 4;
        beats = (total + NB - 1) / NB;
        for (int k = 0; k < beats; k++) begin
            w = '0;
            for (int j = 0; j < NB; j++)
                if (k * NB + j < total) w[DW-1-8*j -: 8] = fb[k * NB + j];
            if (gaps && k % 2 == 1) begin
                in_data = ~w; in_eof_n = 1'b0;
                @(posedge clk); #1;
            end
            put_beat(w, (k == beats - 1) ? (total - 1) % NB : NB - 1, k == 0, k == beats - 1);
        end
    endtask

    // Monitor: collects payload, checks R3, R4, R5, R6, R7 per frame.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (chk_strobe) begin
                strobes++;
                if (nrecv < nsent)
                    check(chk_fail_n == sent_ok[nrecv], "R7 pass/fail flag", chk_fail_n, sent_ok[nrecv]);
            end
            if (!out_src_rdy_n && !out_dst_rdy_n) begin
                for (int j = 0; j <= int'(out_rem); j++)
                    if (rx_n < MAXB) begin rx_b[rx_n] = out_data[DW-1-8*j -: 8]; rx_n++; end
                if (!out_eof_n) begin
                    bit same;
                    bit pad;
                    same = (rx_n == sent_len[nrecv]);
                    for (int i = 0; i < rx_n && same; i++) same = (rx_b[i] == sent_b[nrecv][i]);
                    check(rx_n == sent_len[nrecv], "R4 payload length", rx_n, sent_len[nrecv]);
                    check(same, "R3 payload bytes", nrecv, nrecv);
                    pad = 1'b1;
                    for (int j = 0; j < NB; j++)
                        if (j > int'(out_rem) && out_data[DW-1-8*j -: 8] != 8'h00) pad = 1'b0;
                    check(pad, "R5 lanes after remainder", out_data, 0);
                    check(strobes == 1, "R6 strobe count", strobes, 1);
                    nrecv++; rx_n = 0; strobes = 0;
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_src_rdy_n == 1'b1, "R10 out_src_rdy_n in reset", out_src_rdy_n, 1);
        check(chk_strobe == 1'b0, "R10 strobe in reset", chk_strobe, 0);
        check(chk_fail_n == 1'b1, "R10 fail flag in reset", chk_fail_n, 1);
        @(posedge clk); #1; rst_n = 1'b1;

        // R2: ready passes straight through.
        hold_val = 1'b1; @(posedge clk); #2;
        check(in_dst_rdy_n == 1'b1, "R2 ready high", in_dst_rdy_n, 1);
        hold_val = 1'b0; @(posedge clk); #2;
        check(in_dst_rdy_n == 1'b0, "R2 ready low", in_dst_rdy_n, 0);

        // R1: idle beats with eof set produce nothing.
        begin
            bit quiet;
            quiet = 1'b1;
            in_data = '1; in_eof_n = 1'b0; in_sof_n = 1'b0; in_src_rdy_n = 1'b1;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk); if (!out_src_rdy_n) quiet = 1'b0;
            end
            check(quiet, "R1 idle beats ignored", out_src_rdy_n, 1);
            @(posedge clk); #1;
        end

        // Pass 1: table back to back (R9, R8), no stalls.
        for (int v = 0; v < NV; v++) send_frame(VLEN[v], VFLIP[v], 1'b0);
        // Pass 2: same table with in-frame gaps (R1) and downstream stalls (R11).
        stall_on = 1'b1;
        for (int v = 0; v < NV; v++) send_frame(VLEN[v], VFLIP[v], 1'b1);

        for (int i = 0; i < 200 && nrecv < nsent; i++) @(posedge clk);
        @(negedge clk);
        check(nrecv == nsent, "R9 frames delivered", nrecv, nsent);
        check(strobes == 0, "R6 no stray strobe", strobes, 0);
        done = 1'b1;
        finish_run();
    end
endmodule